// File: doc/BRIEF.md
# Mode-Select Nibble Arithmetic/Logic Slice

This block is a small arithmetic/logic unit for operands of W bits (four by default). A four-bit select code and a mode bit together pick the operation. The same select code does one arithmetic job when the mode bit is low and a related bitwise job when it is high. Arithmetic results take the carry-in into account and wrap modulo 2^W.

The slice also reports three things: whether the two operands are equal, and a group propagate and a group generate. These two are taken from the operand pair that the adder actually sums, so a wider datapath can chain slices through an outside carry network. Every input is sampled on a rising clock edge, and all outputs come from registers. A result therefore appears one cycle after its operands.

Mode encoding: mode = 0 selects arithmetic and mode = 1 selects logic. Select codes are written as sel[3:0], most significant bit first.

Top module: `alu_slice`

## Requirements
- R1: While rst is high at a rising edge, the next register state has f, cout, eq, p and g all at 0. Otherwise every output reflects the inputs sampled at the previous rising edge.
- R2: With mode 0 and sel 0000, f = (A + 1111 + cin) mod 16, which is A − 1 + cin, and cout is bit 4 of that 5-bit sum.
- R3: With mode 0 and sel 0110, f = (A + NOT B + cin) mod 16, which is A − B − 1 + cin, and cout is bit 4 of the 5-bit sum.
- R4: With mode 0 and sel 1001, f = (A + B + cin) mod 16, and cout is bit 4 of the 5-bit sum.
- R5: With mode 0 and sel 1011, f = ((A OR B) + cin) mod 16, and cout is bit 4 of the sum.
- R6: With mode 0 and sel 1100, f = (A + A + cin) mod 16, and cout is bit 4 of the sum.
- R7: With sel 1111, or any code not named in R2–R6, f = (A + cin) mod 16 with cout as bit 4 of the sum in mode 0, and f = A in mode 1.
- R8: In mode 1 the results are: sel 0000 gives NOT A, sel 0110 gives NOT (A XOR B), sel 1001 gives A XOR B, sel 1011 gives A OR B, and sel 1100 gives 0000.
- R9: cout is 0 whenever mode is 1.
- R10: eq is 1 exactly when A equals B, whatever sel, mode and cin are.
- R11: From the operand pair X and Y that the adder sums for the current sel, define per-bit propagate X XOR Y and per-bit generate X AND Y. Then p is the AND of all the propagates, and g is the carry out of X + Y with no carry-in. Both outputs follow this rule in either mode. In mode 0, cout = g OR (p AND cin).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| sel_i | input | 4 | Function select code |
| mode_i | input | 1 | 0 = arithmetic, 1 = logic |
| cin_i | input | 1 | Carry-in for arithmetic |
| f_o | output | W | Registered result |
| cout_o | output | 1 | Registered carry-out |
| eq_o | output | 1 | Registered A-equals-B flag |
| p_o | output | 1 | Registered group propagate |
| g_o | output | 1 | Registered group generate |

## Verification
The assertions assume that the inputs are stable in the cycle before each rising edge. They also assume that reset is held from time zero, so that every past value they refer to was captured outside reset or is masked by the reset condition. The stimulus meets both assumptions. It changes inputs only on falling edges and keeps reset high through the first several edges. It then sweeps every combination of A, B, select, mode and carry-in, one combination per cycle. This sweep reaches the unlisted select codes, the wrap-around sums and the equal-operand cases as a matter of course.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    FN_DEC   = 4'b0000,
    FN_SUBM  = 4'b0110,
    FN_ADD   = 4'b1001,
    FN_ORINC = 4'b1011,
    FN_DBL   = 4'b1100,
    FN_PASS  = 4'b1111
  } fn_code_e;

  localparam logic MODE_ARITH = 1'b0;
  localparam logic MODE_LOGIC = 1'b1;
endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     x,
  output logic [W-1:0]     y
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  // Every arithmetic function is expressed as x + y + cin.
  always_comb begin
    x = a;
    y = ZERO;
    case (sel)
      FN_DEC:   y = ONES;
      FN_SUBM:  y = ~b;
      FN_ADD:   y = b;
      FN_ORINC: x = a | b;
      FN_DBL:   y = a;
      default:  y = ZERO;
    endcase
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         grp_p,
  output logic         grp_g
);
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:0]   carry;
  logic [W:0]   gacc;

  assign carry[0] = cin;
  assign gacc[0]  = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop[i]    = x[i] ^ y[i];
    assign gen[i]     = x[i] & y[i];
    assign sum[i]     = prop[i] ^ carry[i];
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
    assign gacc[i+1]  = gen[i] | (prop[i] & gacc[i]);
  end

  assign cout  = carry[W];
  assign grp_p = &prop;
  assign grp_g = gacc[W];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     f
);
  always_comb begin
    case (sel)
      FN_DEC:   f = ~a;
      FN_SUBM:  f = ~(a ^ b);
      FN_ADD:   f = a ^ b;
      FN_ORINC: f = a | b;
      FN_DBL:   f = '0;
      default:  f = a;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             mode_i,
  input  logic             cin_i,
  output logic [W-1:0]     f_o,
  output logic             cout_o,
  output logic             eq_o,
  output logic             p_o,
  output logic             g_o
);
  logic [W-1:0] opx, opy, arith_f, logic_f;
  logic         arith_c, gp, gg;

  alu_operand_mux #(.W(W)) opmux_i (
    .a(a_i), .b(b_i), .sel(sel_i), .x(opx), .y(opy)
  );

  alu_ripple #(.W(W)) adder_i (
    .x(opx), .y(opy), .cin(cin_i), .sum(arith_f), .cout(arith_c),
    .grp_p(gp), .grp_g(gg)
  );

  alu_logic_unit #(.W(W)) lu_i (
    .a(a_i), .b(b_i), .sel(sel_i), .f(logic_f)
  );

  logic [W-1:0] f_n;
  logic         c_n;

  always_comb begin
    if (mode_i == MODE_LOGIC) begin
      f_n = logic_f;
      c_n = 1'b0;
    end else begin
      f_n = arith_f;
      c_n = arith_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_o    <= '0;
      cout_o <= 1'b0;
      eq_o   <= 1'b0;
      p_o    <= 1'b0;
      g_o    <= 1'b0;
    end else begin
      f_o    <= f_n;
      cout_o <= c_n;
      eq_o   <= (a_i == b_i);
      p_o    <= gp;
      g_o    <= gg;
    end
  end
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [3:0]   sel_i,
  input logic         mode_i,
  input logic         cin_i,
  input logic [W-1:0] f_o,
  input logic         cout_o,
  input logic         eq_o,
  input logic         p_o,
  input logic         g_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (f_o == '0 && !cout_o && !eq_o && !p_o && !g_o)); // R1

  AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) && $past(sel_i) == 4'b1100) |-> f_o == '0); // R8

  AST_LOGIC_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) && $past(sel_i) == 4'b1111) |-> f_o == $past(a_i)); // R7

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i)) |-> !cout_o); // R9

  AST_EQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> eq_o == ($past(a_i) == $past(b_i))); // R10

  AST_GROUP_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_i)) |-> cout_o == (g_o | (p_o & $past(cin_i)))); // R11
endmodule

bind alu_slice alu_slice_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
  .mode_i(mode_i), .cin_i(cin_i), .f_o(f_o), .cout_o(cout_o),
  .eq_o(eq_o), .p_o(p_o), .g_o(g_o)
);

// File: tb/alu_slice_tb_top.sv
module alu_slice_tb_top;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [3:0]   sel_i = '0;
  logic         mode_i = 1'b0, cin_i = 1'b0;
  logic [W-1:0] f_o;
  logic         cout_o, eq_o, p_o, g_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  alu_slice #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
    .mode_i(mode_i), .cin_i(cin_i), .f_o(f_o), .cout_o(cout_o),
    .eq_o(eq_o), .p_o(p_o), .g_o(g_o)
  );

  typedef struct {
    int f; int c; int eq; int p; int g;
    string tag; string ctag;
  } exp_t;

  exp_t q[$];

  function automatic exp_t model(int a, int b, int s, int m, int ci);
    exp_t e;
    int x, y, sum;
    x = a; y = 0;
    case (s)
      0:  begin y = MASK;      e.tag = m ? "R8" : "R2"; end
      6:  begin y = MASK - b;  e.tag = m ? "R8" : "R3"; end
      9:  begin y = b;         e.tag = m ? "R8" : "R4"; end
      11: begin x = a | b;     e.tag = m ? "R8" : "R5"; end
      12: begin y = a;         e.tag = m ? "R8" : "R6"; end
      default: begin y = 0;    e.tag = "R7"; end
    endcase
    sum = x + y + ci;
    if (m == 0) begin
      e.f = sum & MASK;
      e.c = (sum >> W) & 1;
      e.ctag = e.tag;
    end else begin
      case (s)
        0:  e.f = ~a & MASK;
        6:  e.f = ~(a ^ b) & MASK;
        9:  e.f = a ^ b;
        11: e.f = a | b;
        12: e.f = 0;
        default: e.f = a;
      endcase
      e.c = 0;
      e.ctag = "R9";
    end
    e.eq = (a == b) ? 1 : 0;
    e.p = ((x ^ y) == MASK) ? 1 : 0;
    e.g = ((x + y) >> W) & 1;
    return e;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_one();
    exp_t e;
    e = q.pop_front();
    check(e.tag, "f", int'(f_o), e.f);
    check(e.ctag, "cout", int'(cout_o), e.c);
    check("R10", "eq", int'(eq_o), e.eq);
    check("R11", "p", int'(p_o), e.p);
    check("R11", "g", int'(g_o), e.g);
  endtask

  initial begin
    a_i = 4'd5; b_i = 4'd5; sel_i = 4'b1001; mode_i = 1'b0; cin_i = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs cleared while reset is held, even with equal operands
    check("R1", "f", int'(f_o), 0);
    check("R1", "cout", int'(cout_o), 0);
    check("R1", "eq", int'(eq_o), 0);
    check("R1", "p", int'(p_o), 0);
    check("R1", "g", int'(g_o), 0);
    rst = 1'b0;
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
              a_i = a[W-1:0]; b_i = b[W-1:0]; sel_i = s[3:0];
              mode_i = m[0]; cin_i = ci[0];
              q.push_back(model(a, b, s, m, ci));
              @(negedge clk);
              compare_one();
            end
          end
        end
      end
    end
    // R1: a reset in mid-run clears the registers again
    rst = 1'b1;
    a_i = 4'd15; b_i = 4'd15; sel_i = 4'b1100; mode_i = 1'b0; cin_i = 1'b1;
    @(negedge clk);
    check("R1", "f", int'(f_o), 0);
    check("R1", "cout", int'(cout_o), 0);
    check("R1", "eq", int'(eq_o), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule